// File: doc/BRIEF.md
# Link Drive-Level Legalizer

This block turns the per-lane drive adjustment requests that a DisplayPort receiver reports during link training into drive settings the link may legally use. Each lane asks for a voltage swing level and a pre-emphasis level, and may also ask for a post-cursor2 level. The block clamps each request to the allowed range and raises a max-reached flag wherever a level was limited. It then packs the results into the per-lane setting bytes and the post-cursor2 setting bytes that training firmware writes back to the receiver over the AUX channel.

The same clamped 2-bit levels also come out per lane, so they can index a local PHY drive lookup, which lives outside this block. A one-cycle start pulse captures the request bytes, the post-cursor2 request byte and the active lane count. From the next cycle on, done pulses and the outputs hold that result until the next start.

Top module: `lane_drive_legalizer`

## Requirements
- R1: Lane i's request nibble is `adj_req[4i+3:4i]`, which is byte i>>1 at bit offset (i&1)*4. Bits 1:0 of the nibble are the swing request and bits 3:2 are the pre-emphasis request. A request within the limits passes through unchanged, with no flag set.
- R2: When the pre-emphasis request is below 3, the allowed swing is 3 minus the pre-emphasis level. A swing request at or above that value is set to it, and the swing max flag is set.
- R3: A pre-emphasis request of 3 gives pre-emphasis level 3 with its max flag set. The swing is then forced to 0 and its swing max flag stays clear, so the lane byte is 0x38.
- R4: Lane i's setting byte is `lane_set[8i+7:8i]`. Its bits 1:0 hold the swing level, bit 2 the swing max flag, bits 4:3 the pre-emphasis level, bit 5 the pre-emphasis max flag, and bits 7:6 are 0.
- R5: Lane i's post-cursor2 request is `pc2_req[2i+1:2i]`. A request below 3 passes through unchanged. A request of 3 gives level 3 with the post-cursor2 max flag set.
- R6: Lane i's post-cursor2 nibble is `pc2_set[4i+3:4i]`, which is byte i>>1 at offset (i&1)*4. Its bits 1:0 hold the level, bit 2 the max flag, and bit 3 is 0.
- R7: A lane whose index is at or above the captured lane count is inactive. All of its outputs are 0: the setting byte, the post-cursor2 nibble and its three drive levels.
- R8: `drv_swing`, `drv_pre` and `drv_pc2` carry each lane's clamped 2-bit level at bits [2i+1:2i], without flags.
- R9: done is high for exactly the one cycle after a cycle with start high. All outputs change only in the cycle after start, and they hold between starts even when the inputs change.
- R10: After reset, done is 0 and every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Capture pulse for the request inputs |
| adj_req | input | 16 | Adjust request bytes, 4 bits per lane |
| pc2_req | input | 8 | Post-cursor2 request byte, 2 bits per lane |
| lane_cnt | input | 3 | Active lane count (1, 2 or 4 in normal use) |
| done | output | 1 | One-cycle pulse: new results are valid |
| lane_set | output | 32 | Four packed lane setting bytes |
| pc2_set | output | 16 | Two packed post-cursor2 setting bytes |
| drv_swing | output | 8 | Clamped swing level per lane |
| drv_pre | output | 8 | Clamped pre-emphasis level per lane |
| drv_pc2 | output | 8 | Clamped post-cursor2 level per lane |

## Verification
The hardest case to reach from the ports combines pre-emphasis saturation with a high swing request in a lane that is also cut off by the lane count. Here three rules overlap: the forced swing, the missing swing flag and the zeroing of inactive lanes. The stimulus puts a saturating request in the high nibble of each adjust byte while the lane count is stepped through 1, 2, 3, 4 and 0. It also sweeps all sixteen nibble values through every lane position. The request inputs also change between start pulses, so that any leak of the live inputs into the held result shows up.

// File: rtl/lane_drive_pkg.sv
package lane_drive_pkg;

   localparam int LVL_W   = 2;
   localparam int LVL_TOP = 3;

   typedef struct packed {
      logic [LVL_W-1:0] sw;
      logic             sw_max;
      logic [LVL_W-1:0] pre;
      logic             pre_max;
      logic [LVL_W-1:0] pc2;
      logic             pc2_max;
   } lane_drv_t;

   function automatic logic [7:0] set_byte(input lane_drv_t d);
      return {2'b00, d.pre_max, d.pre, d.sw_max, d.sw};
   endfunction

   function automatic logic [3:0] pc2_nibble(input lane_drv_t d);
      return {1'b0, d.pc2_max, d.pc2};
   endfunction

endpackage

// File: rtl/ldl_unpack.sv
module ldl_unpack #(
   parameter int LANES = 4,
   parameter int CNT_W = 3
) (
   input  logic [LANES*4-1:0] adj_flat,
   input  logic [LANES*2-1:0] pc2_flat,
   input  logic [CNT_W-1:0]   cnt,
   output logic [3:0]         req_nib [LANES],
   output logic [1:0]         pc2_lvl [LANES],
   output logic [LANES-1:0]   active
);
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      // byte i>>1, offset (i&1)*4 coincides with flat nibble i
      assign req_nib[i] = adj_flat[4*i +: 4];
      assign pc2_lvl[i] = pc2_flat[2*i +: 2];
      assign active[i]  = (CNT_W'(i) < cnt);
   end
endmodule

// File: rtl/ldl_lane_clamp.sv
module ldl_lane_clamp
   import lane_drive_pkg::*;
#(
   parameter bit PC2_EN = 1'b1
) (
   input  logic [3:0] req_nib,
   input  logic [1:0] pc2_req,
   input  logic       active,
   output lane_drv_t  drv
);
   logic [1:0] sw_req, pre_req, sw_ceil;
   lane_drv_t  raw;

   assign sw_req  = req_nib[1:0];
   assign pre_req = req_nib[3:2];
   assign sw_ceil = 2'(LVL_TOP) - pre_req;

   always_comb begin
      raw = '0;
      if (pre_req >= 2'(LVL_TOP)) begin
         raw.pre     = 2'(LVL_TOP);
         raw.pre_max = 1'b1;
         raw.sw      = 2'd0;
         raw.sw_max  = 1'b0;
      end else begin
         raw.pre = pre_req;
         if (sw_req >= sw_ceil) begin
            raw.sw     = sw_ceil;
            raw.sw_max = 1'b1;
         end else begin
            raw.sw = sw_req;
         end
      end
   end

   if (PC2_EN) begin : g_pc2
      lane_drv_t with_pc2;
      always_comb begin
         with_pc2         = raw;
         with_pc2.pc2     = pc2_req;
         with_pc2.pc2_max = (pc2_req >= 2'(LVL_TOP));
      end
      assign drv = active ? with_pc2 : '0;
   end else begin : g_no_pc2
      logic unused_pc2;
      assign unused_pc2 = ^pc2_req;
      assign drv = active ? raw : '0;
   end
endmodule

// File: rtl/ldl_pack.sv
module ldl_pack
   import lane_drive_pkg::*;
#(
   parameter int LANES = 4
) (
   input  lane_drv_t        drv [LANES],
   output logic [LANES*8-1:0] lane_set,
   output logic [LANES*4-1:0] pc2_set,
   output logic [LANES*2-1:0] drv_swing,
   output logic [LANES*2-1:0] drv_pre,
   output logic [LANES*2-1:0] drv_pc2
);
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign lane_set[8*i +: 8]  = set_byte(drv[i]);
      assign pc2_set[4*i +: 4]   = pc2_nibble(drv[i]);
      assign drv_swing[2*i +: 2] = drv[i].sw;
      assign drv_pre[2*i +: 2]   = drv[i].pre;
      assign drv_pc2[2*i +: 2]   = drv[i].pc2;
   end
endmodule

// File: rtl/lane_drive_legalizer.sv
module lane_drive_legalizer
   import lane_drive_pkg::*;
#(
   parameter int LANES  = 4,
   parameter bit PC2_EN = 1'b1,
   localparam int CNT_W = $clog2(LANES + 1) < 1 ? 1 : $clog2(LANES + 1),
   localparam int ADJ_W = LANES * 4,
   localparam int PC2_W = LANES * 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [ADJ_W-1:0]   adj_req,
   input  logic [PC2_W-1:0]   pc2_req,
   input  logic [CNT_W-1:0]   lane_cnt,
   output logic               done,
   output logic [LANES*8-1:0] lane_set,
   output logic [LANES*4-1:0] pc2_set,
   output logic [PC2_W-1:0]   drv_swing,
   output logic [PC2_W-1:0]   drv_pre,
   output logic [PC2_W-1:0]   drv_pc2
);
   if (LANES < 2 || (LANES % 2) != 0)
      $error("LANES must be even and at least 2");
   if (LANES > 8)
      $error("LANES above 8 is not supported");

   logic [ADJ_W-1:0] adj_q;
   logic [PC2_W-1:0] pc2_q;
   logic [CNT_W-1:0] cnt_q;
   logic             done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         adj_q  <= '0;
         pc2_q  <= '0;
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= start;
         if (start) begin
            adj_q <= adj_req;
            pc2_q <= pc2_req;
            cnt_q <= lane_cnt;
         end
      end
   end

   logic [3:0]       req_nib [LANES];
   logic [1:0]       pc2_lvl [LANES];
   logic [LANES-1:0] active;
   lane_drv_t        drv     [LANES];

   ldl_unpack #(.LANES(LANES), .CNT_W(CNT_W)) u_unpack (
      .adj_flat (adj_q),
      .pc2_flat (pc2_q),
      .cnt      (cnt_q),
      .req_nib  (req_nib),
      .pc2_lvl  (pc2_lvl),
      .active   (active)
   );

   for (genvar i = 0; i < LANES; i++) begin : g_clamp
      ldl_lane_clamp #(.PC2_EN(PC2_EN)) u_clamp (
         .req_nib (req_nib[i]),
         .pc2_req (pc2_lvl[i]),
         .active  (active[i]),
         .drv     (drv[i])
      );
   end

   ldl_pack #(.LANES(LANES)) u_pack (
      .drv       (drv),
      .lane_set  (lane_set),
      .pc2_set   (pc2_set),
      .drv_swing (drv_swing),
      .drv_pre   (drv_pre),
      .drv_pc2   (drv_pc2)
   );

   assign done = done_q;
endmodule

// File: rtl/lane_drive_legalizer_chk.sv
module lane_drive_legalizer_chk #(
   parameter int LANES = 4,
   parameter int CNT_W = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               start,
   input logic [CNT_W-1:0]   lane_cnt,
   input logic               done,
   input logic [LANES*8-1:0] lane_set,
   input logic [LANES*4-1:0] pc2_set
);
   assert_done_after_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> done);
   assert_no_done_without_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> !done);
   assert_hold_between_starts_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> ($stable(lane_set) && $stable(pc2_set)));

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assert_swing_ceiling_R2: assert property (@(posedge clk) disable iff (!rst_n)
         ({1'b0, lane_set[8*i +: 2]} + {1'b0, lane_set[8*i+3 +: 2]}) <= 3'd3);
      assert_pre_saturation_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (lane_set[8*i+3 +: 3] == 3'b111) |-> (lane_set[8*i +: 3] == 3'b000));
      assert_top_bits_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
         lane_set[8*i+6 +: 2] == 2'b00);
      assert_inactive_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (start && (lane_cnt <= CNT_W'(i))) |=>
            (lane_set[8*i +: 8] == 8'h00 && pc2_set[4*i +: 4] == 4'h0));
   end
endmodule

bind lane_drive_legalizer lane_drive_legalizer_chk #(.LANES(LANES), .CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .lane_cnt (lane_cnt),
   .done     (done),
   .lane_set (lane_set),
   .pc2_set  (pc2_set)
);

// File: tb/lane_drive_legalizer_bench.sv
`timescale 1ns/1ps
module lane_drive_legalizer_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] adj_req = '0;
   logic [7:0]  pc2_req = '0;
   logic [2:0]  lane_cnt = '0;
   logic        done;
   logic [31:0] lane_set;
   logic [15:0] pc2_set;
   logic [7:0]  drv_swing, drv_pre, drv_pc2;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   lane_drive_legalizer u_lane_drive_legalizer (
      .clk, .rst_n, .start, .adj_req, .pc2_req, .lane_cnt,
      .done, .lane_set, .pc2_set, .drv_swing, .drv_pre, .drv_pc2
   );

   // reference model state
   int  m_sw [4], m_swf [4], m_pre [4], m_pref [4], m_pc [4], m_pcf [4];
   bit  m_done = 1'b0;

   task automatic model_lane(input int i, input int nib, input int pc, input bit act);
      int rs, rp;
      rs = nib % 4;
      rp = nib / 4;
      m_sw[i] = 0; m_swf[i] = 0; m_pre[i] = 0; m_pref[i] = 0; m_pc[i] = 0; m_pcf[i] = 0;
      if (act) begin
         if (rp >= 3) begin
            m_pre[i] = 3; m_pref[i] = 1; m_sw[i] = 0;
         end else begin
            m_pre[i] = rp;
            if (rs >= 3 - rp) begin m_sw[i] = 3 - rp; m_swf[i] = 1; end
            else m_sw[i] = rs;
         end
         if (pc >= 3) begin m_pc[i] = 3; m_pcf[i] = 1; end
         else m_pc[i] = pc;
      end
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_done <= 1'b0;
         for (int i = 0; i < 4; i++) model_lane(i, 0, 0, 1'b0);
      end else begin
         m_done <= start;
         if (start)
            for (int i = 0; i < 4; i++)
               model_lane(i, (adj_req >> (4*i)) & 15, (pc2_req >> (2*i)) & 3, i < lane_cnt);
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // compare against the model on every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         logic [31:0] e_ls;
         logic [15:0] e_pc;
         logic [7:0]  e_sw, e_pr, e_p2;
         for (int i = 0; i < 4; i++) begin
            e_ls[8*i +: 8] = 8'((m_pref[i] << 5) | (m_pre[i] << 3) | (m_swf[i] << 2) | m_sw[i]);
            e_pc[4*i +: 4] = 4'((m_pcf[i] << 2) | m_pc[i]);
            e_sw[2*i +: 2] = 2'(m_sw[i]);
            e_pr[2*i +: 2] = 2'(m_pre[i]);
            e_p2[2*i +: 2] = 2'(m_pc[i]);
         end
         check("R9 done", {31'd0, done}, {31'd0, m_done});
         check("R4 lane_set", lane_set, e_ls);
         check("R6 pc2_set", {16'd0, pc2_set}, {16'd0, e_pc});
         check("R8 drv_swing", {24'd0, drv_swing}, {24'd0, e_sw});
         check("R8 drv_pre", {24'd0, drv_pre}, {24'd0, e_pr});
         check("R8 drv_pc2", {24'd0, drv_pc2}, {24'd0, e_p2});
      end
   end

   task automatic fire(input logic [15:0] a, input logic [7:0] p, input logic [2:0] c);
      @(negedge clk);
      adj_req = a; pc2_req = p; lane_cnt = c; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset state
      check("R10 done", {31'd0, done}, 32'd0);
      check("R10 lane_set", lane_set, 32'd0);
      check("R10 pc2_set", {16'd0, pc2_set}, 32'd0);
      rst_n = 1'b1;

      // lanes: 0 sw3 pre0, 1 sw2 pre3, 2 sw2 pre1, 3 sw0 pre1
      fire(16'h46E3, 8'h87, 3'd4);
      check("R2 lane0 byte", {24'd0, lane_set[7:0]}, 32'h07);
      check("R3 lane1 byte", {24'd0, lane_set[15:8]}, 32'h38);
      check("R2 lane2 byte", {24'd0, lane_set[23:16]}, 32'h0E);
      check("R1 lane3 byte", {24'd0, lane_set[31:24]}, 32'h08);
      check("R5 pc2 bytes", {16'd0, pc2_set}, 32'h2017);
      check("R8 levels", {8'd0, drv_swing, drv_pre, drv_pc2}, 32'h00235C87);
      check("R9 done pulse", {31'd0, done}, 32'd1);

      // R9: inputs change without start, result holds
      @(negedge clk);
      adj_req = 16'hFFFF; pc2_req = 8'hFF; lane_cnt = 3'd1;
      repeat (3) @(negedge clk);
      check("R9 hold", lane_set, 32'h080E3807);
      check("R9 done low", {31'd0, done}, 32'd0);

      // R7: lane count two
      fire(16'h46E3, 8'h87, 3'd2);
      check("R7 two lanes", lane_set, 32'h00003807);
      check("R7 two lanes pc2", {16'd0, pc2_set}, 32'h0017);
      fire(16'hEEEE, 8'hFF, 3'd0);
      check("R7 zero lanes", lane_set, 32'h0);

      // lane count sweep with saturating high nibbles, back-to-back starts
      for (int c = 0; c <= 4; c++) fire(16'hE7E7, 8'hFF, 3'(c));
      for (int c = 4; c >= 0; c--) begin
         @(negedge clk);
         adj_req = 16'hDBE5; pc2_req = 8'h1B; lane_cnt = 3'(c); start = 1'b1;
      end
      @(negedge clk); start = 1'b0;

      // all nibble values through each lane position
      for (int n = 0; n < 16; n++)
         for (int pos = 0; pos < 4; pos++)
            fire(16'((n << (4*pos)) | (16'h1111 & ~(16'hF << (4*pos)))), 8'(n * 17), 3'd4);

      for (int k = 0; k < 300; k++)
         fire(16'($urandom), 8'($urandom), 3'($urandom_range(0, 4)));

      repeat (2) @(negedge clk);
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected<=100000 cycles", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule